// File: doc/BRIEF.md
# Circular Auto-Buffering DMA Unit

This unit moves words between a serial port and an on-chip memory window with no processor involvement. Each direction has its own circular pointer with a programmable base address and length, inside a 2048-word window. A word arriving from the serial port is written to the next receive slot. The next transmit word is fetched from memory as soon as the serial port's holding register empties, so the holding register is refilled before the next word boundary.

The unit raises an interrupt when a buffer is half done and another when it is fully done. A status bit shows which half has just completed. Each direction can optionally switch itself off when its buffer completes. While a direction is inactive, whether it was never enabled, was disabled, or stopped itself, its word events from the serial port go straight to that direction's interrupt output.

The base address and the length minus one are sampled when a direction's enable goes high. Addresses are 11 bits wide and wrap inside the window. The memory port is a single synchronous port with one cycle of read latency and no wait states. When both directions need it in the same cycle, the receive side goes first.

Top module: `abuf_dma`

## Requirements
- R1: After reset the unit issues no memory access, both interrupt outputs are low, both half-status bits are 0, and `txLoad` is low.
- R2: In the cycle after a sampled `rxWordValid` on an active receive side, the unit writes the captured word (`memReq`=1, `memWe`=1) to address base+index. The index runs 0..lenM1 and then returns to 0.
- R3: Address arithmetic wraps modulo 2048, so a buffer whose base lies near the top of the window continues at address 0.
- R4: For the receive side, `rxIrq` pulses for one cycle, in the cycle after the write, when index ((lenM1+1)>>1)-1 is written (`rxHalf`=1) and when index lenM1 is written (`rxHalf`=0). The half-point pulse is skipped when lenM1 is 0.
- R5: With receive auto-stop set, the write of index lenM1 makes the receive side inactive, and it issues no further writes.
- R6: A rising transmit enable, or a sampled `txWordTaken` while transmit is active, causes a read (`memReq`=1, `memWe`=0) at base+index. In the following cycle `txLoad`=1 and `txWord` carries the memory data.
- R7: `txIrq` and `txHalf` follow the rule of R4, using the fetched transmit index, and are asserted together with the `txLoad` of that word.
- R8: With transmit auto-stop set, fetching index lenM1 makes the transmit side inactive, and it issues no further reads.
- R9: While a direction is inactive, `rxIrq` equals `rxWordValid` and `txIrq` equals `txWordTaken` in the same cycle, and the events cause no memory access.
- R10: When a receive write and a transmit read are due in the same cycle, the write is issued first and the read follows in the next cycle.
- R11: If the enable is cleared in the same cycle as an accepted receive word, that word is still written. Later words are not written and pass through as interrupts.
- R12: With lenM1=0, every word uses the base address and raises an end interrupt with half-status 0.
- R13: Without auto-stop, a direction keeps cycling through its buffer, and the half and end interrupts repeat on every pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive auto-buffering enable; a rising edge loads the receive configuration |
| txEnable | input | 1 | Transmit auto-buffering enable; a rising edge loads the transmit configuration and starts a prefetch |
| rxAutoStop | input | 1 | Deactivate receive when its buffer completes |
| txAutoStop | input | 1 | Deactivate transmit when its buffer completes |
| rxStart | input | 11 | Receive buffer base address |
| rxLenM1 | input | 11 | Receive buffer length minus one |
| txStart | input | 11 | Transmit buffer base address |
| txLenM1 | input | 11 | Transmit buffer length minus one |
| rxWordValid | input | 1 | Serial port received a word (one-cycle pulse) |
| rxWord | input | 16 | Received word |
| txWordTaken | input | 1 | Serial port emptied its transmit holding register (one-cycle pulse) |
| txLoad | output | 1 | Load `txWord` into the transmit holding register |
| txWord | output | 16 | Word for the transmit holding register |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 11 | Memory word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid the cycle after a read |
| rxIrq | output | 1 | Receive interrupt (buffer event or pass-through) |
| txIrq | output | 1 | Transmit interrupt (buffer event or pass-through) |
| rxHalf | output | 1 | 1 = first receive half just finished, 0 = end of buffer |
| txHalf | output | 1 | 1 = first transmit half just finished, 0 = end of buffer |

## Verification
The assertions assume that a direction's enable is raised only after that direction has gone idle, with no receive write pending. They also assume that the base and length inputs do not change while the enable rises, and that `txWordTaken` never pulses again before the word it requested has been loaded. The bench keeps within these limits. Before every reconfiguration it holds the enable low for two cycles. It waits for each receive write and each transmit load before sending the next event, and it forces the two directions into contention only once, in a cycle where each has at most one outstanding request.

// File: rtl/abuf_pkg.sv
package abuf_pkg;

  // Strobes from the control to the datapath, all valid for one cycle.
  typedef struct packed {
    logic rxLoad;     // sample receive base and length, clear index
    logic txLoad;     // sample transmit base and length, clear index
    logic rxCapture;  // latch the incoming receive word
    logic rxWrite;    // issue the receive memory write and step the index
    logic txRead;     // issue the transmit memory read and step the index
  } abufStrobes_t;

endpackage

// File: rtl/abuf_ptr.sv
module abuf_ptr #(
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [AddrW-1:0] startIn,
  input  logic [AddrW-1:0] lenM1In,
  output logic [AddrW-1:0] addr,
  output logic             atHalf,
  output logic             atEnd
);
  localparam int LenW = AddrW + 1;

  logic [AddrW-1:0] startQ, lenM1Q, idxQ;
  logic [LenW-1:0]  halfIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      lenM1Q <= '0;
      idxQ   <= '0;
    end else if (load) begin
      startQ <= startIn;
      lenM1Q <= lenM1In;
      idxQ   <= '0;
    end else if (step) begin
      idxQ <= atEnd ? '0 : idxQ + AddrW'(1);
    end
  end

  always_comb begin
    halfIdx = (({1'b0, lenM1Q} + LenW'(1)) >> 1) - LenW'(1);
    addr    = startQ + idxQ;
    atEnd   = (idxQ == lenM1Q);
    atHalf  = (lenM1Q != '0) && ({1'b0, idxQ} == halfIdx);
  end

  // R2: the index never leaves the programmed buffer
  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= lenM1Q);

  // R2: stepping past the last slot lands on the base address
  p_wrap_to_base_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && atEnd && !load) |=> (addr == startQ));

  // R4: the half point and the end point are never the same slot
  p_half_not_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    atHalf |-> !atEnd);

endmodule

// File: rtl/abuf_dpath.sv
module abuf_dpath import abuf_pkg::*; #(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  abufStrobes_t     stb,
  input  logic [AddrW-1:0] rxStart,
  input  logic [AddrW-1:0] rxLenM1,
  input  logic [AddrW-1:0] txStart,
  input  logic [AddrW-1:0] txLenM1,
  input  logic [DataW-1:0] rxWord,
  output logic             rxAtHalf,
  output logic             rxAtEnd,
  output logic             txAtHalf,
  output logic             txAtEnd,
  output logic             memReq,
  output logic             memWe,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata
);
  logic [AddrW-1:0] rxAddr, txAddr;
  logic [DataW-1:0] rxDataQ;

  abuf_ptr #(.AddrW(AddrW)) i_rxPtr (
    .clk(clk), .rstN(rstN), .load(stb.rxLoad), .step(stb.rxWrite),
    .startIn(rxStart), .lenM1In(rxLenM1),
    .addr(rxAddr), .atHalf(rxAtHalf), .atEnd(rxAtEnd)
  );

  abuf_ptr #(.AddrW(AddrW)) i_txPtr (
    .clk(clk), .rstN(rstN), .load(stb.txLoad), .step(stb.txRead),
    .startIn(txStart), .lenM1In(txLenM1),
    .addr(txAddr), .atHalf(txAtHalf), .atEnd(txAtEnd)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              rxDataQ <= '0;
    else if (stb.rxCapture) rxDataQ <= rxWord;
  end

  always_comb begin
    memReq   = stb.rxWrite | stb.txRead;
    memWe    = stb.rxWrite;
    memAddr  = stb.rxWrite ? rxAddr : txAddr;
    memWdata = rxDataQ;
  end

  // R10: the port carries one access at a time
  p_single_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rxWrite && stb.txRead));

endmodule

// File: rtl/abuf_ctrl.sv
module abuf_ctrl import abuf_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxEnable,
  input  logic         txEnable,
  input  logic         rxAutoStop,
  input  logic         txAutoStop,
  input  logic         rxWordValid,
  input  logic         txWordTaken,
  input  logic         rxAtHalf,
  input  logic         rxAtEnd,
  input  logic         txAtHalf,
  input  logic         txAtEnd,
  output abufStrobes_t stb,
  output logic         txLoad,
  output logic         rxIrq,
  output logic         txIrq,
  output logic         rxHalf,
  output logic         txHalf
);
  logic rxEnQ, txEnQ, rxActiveQ, txActiveQ;
  logic rxPendQ, txNeedQ, txRdQ;
  logic rxIrqQ, txIrqQ, rxHalfQ, txHalfQ;
  logic rxRise, txRise, rxAccept;

  always_comb begin
    rxRise        = rxEnable & ~rxEnQ;
    txRise        = txEnable & ~txEnQ;
    rxAccept      = rxActiveQ & rxWordValid;
    stb.rxLoad    = rxRise;
    stb.txLoad    = txRise;
    stb.rxCapture = rxAccept;
    stb.rxWrite   = rxPendQ;
    stb.txRead    = txActiveQ & txNeedQ & ~rxPendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnQ <= 1'b0;  txEnQ <= 1'b0;
      rxActiveQ <= 1'b0;  txActiveQ <= 1'b0;
      rxPendQ <= 1'b0;  txNeedQ <= 1'b0;  txRdQ <= 1'b0;
      rxIrqQ <= 1'b0;  txIrqQ <= 1'b0;
      rxHalfQ <= 1'b0;  txHalfQ <= 1'b0;
    end else begin
      rxEnQ   <= rxEnable;
      txEnQ   <= txEnable;
      rxPendQ <= rxAccept;
      txRdQ   <= stb.txRead;
      txNeedQ <= txRise | (txNeedQ & ~stb.txRead) | (txActiveQ & txWordTaken);

      if (rxRise)                                     rxActiveQ <= 1'b1;
      else if (!rxEnable)                             rxActiveQ <= 1'b0;
      else if (stb.rxWrite && rxAtEnd && rxAutoStop)  rxActiveQ <= 1'b0;

      if (txRise)                                     txActiveQ <= 1'b1;
      else if (!txEnable)                             txActiveQ <= 1'b0;
      else if (stb.txRead && txAtEnd && txAutoStop)   txActiveQ <= 1'b0;

      rxIrqQ <= stb.rxWrite & (rxAtHalf | rxAtEnd);
      if (stb.rxWrite && (rxAtHalf || rxAtEnd)) rxHalfQ <= rxAtHalf;

      txIrqQ <= stb.txRead & (txAtHalf | txAtEnd);
      if (stb.txRead && (txAtHalf || txAtEnd)) txHalfQ <= txAtHalf;
    end
  end

  always_comb begin
    txLoad = txRdQ;
    rxIrq  = rxIrqQ | (~rxActiveQ & rxWordValid);
    txIrq  = txIrqQ | (~txActiveQ & txWordTaken);
    rxHalf = rxHalfQ;
    txHalf = txHalfQ;
  end

  // R2: an accepted receive word is written in the next cycle
  p_rx_write_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxActiveQ && rxWordValid) |=> stb.rxWrite);

  // R5: auto-stop ends receive activity at the last slot
  p_rx_autostop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxWrite && rxAtEnd && rxAutoStop && !rxRise) |=> !rxActiveQ);

  // R8: auto-stop ends transmit activity at the last slot
  p_tx_autostop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txRead && txAtEnd && txAutoStop && !txRise) |=> !txActiveQ);

  // R10: a transmit fetch blocked by a receive write is issued next
  p_tx_deferred_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxPendQ && txActiveQ && txNeedQ && txEnable && !rxWordValid) |=> stb.txRead);

endmodule

// File: rtl/abuf_dma.sv
module abuf_dma import abuf_pkg::*; #(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic             rxAutoStop,
  input  logic             txAutoStop,
  input  logic [AddrW-1:0] rxStart,
  input  logic [AddrW-1:0] rxLenM1,
  input  logic [AddrW-1:0] txStart,
  input  logic [AddrW-1:0] txLenM1,
  input  logic             rxWordValid,
  input  logic [DataW-1:0] rxWord,
  input  logic             txWordTaken,
  output logic             txLoad,
  output logic [DataW-1:0] txWord,
  output logic             memReq,
  output logic             memWe,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  input  logic [DataW-1:0] memRdata,
  output logic             rxIrq,
  output logic             txIrq,
  output logic             rxHalf,
  output logic             txHalf
);
  abufStrobes_t stb;
  logic rxAtHalf, rxAtEnd, txAtHalf, txAtEnd;

  abuf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .rxEnable(rxEnable), .txEnable(txEnable),
    .rxAutoStop(rxAutoStop), .txAutoStop(txAutoStop),
    .rxWordValid(rxWordValid), .txWordTaken(txWordTaken),
    .rxAtHalf(rxAtHalf), .rxAtEnd(rxAtEnd),
    .txAtHalf(txAtHalf), .txAtEnd(txAtEnd),
    .stb(stb), .txLoad(txLoad),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxHalf(rxHalf), .txHalf(txHalf)
  );

  abuf_dpath #(.AddrW(AddrW), .DataW(DataW)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxStart(rxStart), .rxLenM1(rxLenM1),
    .txStart(txStart), .txLenM1(txLenM1),
    .rxWord(rxWord),
    .rxAtHalf(rxAtHalf), .rxAtEnd(rxAtEnd),
    .txAtHalf(txAtHalf), .txAtEnd(txAtEnd),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign txWord = memRdata;

  // R6: the word fetched for transmit is offered exactly one cycle later
  p_tx_load_follows_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> txLoad);

endmodule

// File: tb/test_abuf_dma.sv
module test_abuf_dma;
  localparam int AddrW = 11;
  localparam int DataW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 0, txEnable = 0, rxAutoStop = 0, txAutoStop = 0;
  logic [AddrW-1:0] rxStart = '0, rxLenM1 = '0, txStart = '0, txLenM1 = '0;
  logic rxWordValid = 0, txWordTaken = 0;
  logic [DataW-1:0] rxWord = '0;
  logic txLoad, memReq, memWe, rxIrq, txIrq, rxHalf, txHalf;
  logic [DataW-1:0] txWord, memWdata;
  logic [DataW-1:0] memRdata = '0;
  logic [AddrW-1:0] memAddr;

  logic [DataW-1:0] mem [2048];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  abuf_dma #(.AddrW(AddrW), .DataW(DataW)) i_abuf_dma (
    .clk(clk), .rstN(rstN),
    .rxEnable(rxEnable), .txEnable(txEnable),
    .rxAutoStop(rxAutoStop), .txAutoStop(txAutoStop),
    .rxStart(rxStart), .rxLenM1(rxLenM1), .txStart(txStart), .txLenM1(txLenM1),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .txWordTaken(txWordTaken),
    .txLoad(txLoad), .txWord(txWord),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxHalf(rxHalf), .txHalf(txHalf)
  );

  initial for (int i = 0; i < 2048; i++) mem[i] = DataW'(i) ^ 16'hA5A5;

  always @(posedge clk) begin
    if (memReq && memWe)  mem[memAddr] <= memWdata;
    else if (memReq)      memRdata <= mem[memAddr];
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic rxOne(input string req, input logic [AddrW-1:0] adr,
                       input logic [DataW-1:0] d, input logic irqE, input logic halfE);
    rxWordValid = 1'b1; rxWord = d;
    tick();
    rxWordValid = 1'b0;
    chk({req, " write strobe"}, {memReq, memWe}, 2'b11);
    chk({req, " write address"}, memAddr, adr);
    chk({req, " write data"}, memWdata, d);
    tick();
    chk({req, " irq"}, rxIrq, irqE);
    if (irqE) chk({req, " half status"}, rxHalf, halfE);
  endtask

  task automatic rxRestart(input logic [AddrW-1:0] b, input logic [AddrW-1:0] l, input logic stop);
    rxEnable = 1'b0; tick(); tick();
    rxStart = b; rxLenM1 = l; rxAutoStop = stop; rxEnable = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 memReq", memReq, 0);
    chk("R1 irqs", {rxIrq, txIrq}, 0);
    chk("R1 half bits", {rxHalf, txHalf}, 0);
    chk("R1 txLoad", txLoad, 0);
  endtask

  task automatic t_passthru();
    rxWordValid = 1'b1; #1;
    chk("R9 rx pass-through", rxIrq, 1);
    chk("R9 no access on rx", memReq, 0);
    tick(); rxWordValid = 1'b0;
    chk("R9 no write later", memReq, 0);
    txWordTaken = 1'b1; #1;
    chk("R9 tx pass-through", txIrq, 1);
    tick(); txWordTaken = 1'b0;
    chk("R9 no read later", memReq, 0);
  endtask

  task automatic t_rx_buffer();
    rxRestart(11'd100, 11'd3, 1'b1);
    for (int k = 0; k < 4; k++)
      rxOne("R2 R4 rx buffer", 11'd100 + 11'(k), 16'h1000 + 16'(k), (k == 1) || (k == 3), k == 1);
    rxWordValid = 1'b1; #1;
    chk("R5 stopped rx passes through", rxIrq, 1);
    tick(); rxWordValid = 1'b0;
    chk("R5 no write after stop", memReq, 0);
  endtask

  task automatic t_rx_window();
    rxRestart(11'd2046, 11'd4, 1'b0);
    for (int k = 0; k < 7; k++) begin
      int idx = k % 5;
      rxOne("R3 R13 window wrap", 11'((2046 + idx) % 2048), 16'h2000 + 16'(k),
            (idx == 1) || (idx == 4), idx == 1);
    end
  endtask

  task automatic t_rx_len1();
    rxRestart(11'd7, 11'd0, 1'b0);
    for (int k = 0; k < 3; k++) rxOne("R12 single slot", 11'd7, 16'h3000 + 16'(k), 1'b1, 1'b0);
  endtask

  task automatic t_tx();
    txStart = 11'd500; txLenM1 = 11'd3; txAutoStop = 1'b1; txEnable = 1'b1;
    tick();
    chk("R6 prefetch read", {memReq, memWe}, 2'b10);
    chk("R6 prefetch address", memAddr, 11'd500);
    tick();
    chk("R6 first load", txLoad, 1);
    chk("R6 first word", txWord, mem[500]);
    chk("R7 no irq at slot 0", txIrq, 0);
    for (int k = 1; k < 4; k++) begin
      txWordTaken = 1'b1; tick(); txWordTaken = 1'b0;
      chk("R6 refill read", {memReq, memWe}, 2'b10);
      chk("R6 refill address", memAddr, 11'd500 + 11'(k));
      tick();
      chk("R6 refill load", txLoad, 1);
      chk("R6 refill word", txWord, mem[500 + k]);
      chk("R7 tx irq", txIrq, (k == 1) || (k == 3));
      if (k == 1 || k == 3) chk("R7 tx half status", txHalf, k == 1);
    end
    txWordTaken = 1'b1; #1;
    chk("R8 stopped tx passes through", txIrq, 1);
    chk("R8 no access", memReq, 0);
    tick(); txWordTaken = 1'b0;
    chk("R8 no read after stop", memReq, 0);
  endtask

  task automatic t_priority();
    txEnable = 1'b0; tick(); tick();
    txStart = 11'd600; txLenM1 = 11'd7; txAutoStop = 1'b0;
    txEnable = 1'b1; rxWordValid = 1'b1; rxWord = 16'hBEEF;
    tick(); rxWordValid = 1'b0;
    chk("R10 write goes first", {memReq, memWe}, 2'b11);
    chk("R10 write address", memAddr, 11'd7);
    tick();
    chk("R10 read follows", {memReq, memWe}, 2'b10);
    chk("R10 read address", memAddr, 11'd600);
    chk("R12 end irq", rxIrq, 1);
    tick();
    chk("R10 deferred load", txLoad, 1);
    chk("R10 deferred word", txWord, mem[600]);
  endtask

  task automatic t_disable_mid();
    rxRestart(11'd300, 11'd7, 1'b0);
    rxWordValid = 1'b1; rxWord = 16'h55AA; rxEnable = 1'b0;
    tick(); rxWordValid = 1'b0;
    chk("R11 current word written", {memReq, memWe}, 2'b11);
    chk("R11 address", memAddr, 11'd300);
    chk("R11 data", memWdata, 16'h55AA);
    tick();
    chk("R11 stored", mem[300], 16'h55AA);
    rxWordValid = 1'b1; #1;
    chk("R11 later word passes through", rxIrq, 1);
    tick(); rxWordValid = 1'b0;
    chk("R11 later word not written", memReq, 0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_passthru();
    t_rx_buffer();
    t_rx_window();
    t_rx_len1();
    t_tx();
    t_priority();
    t_disable_mid();
    tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule